// File: doc/BRIEF.md
# SONET B1/B2 BIP Parity Monitor

This block watches the receive byte stream of a SONET/SDH line and checks two bit-interleaved parities in every frame. The section parity (B1) is an even BIP-8 over every byte of a frame in its scrambled form. The line parity (B2) is a set of BIP-8 lanes over the descrambled bytes of the line overhead and the payload, with one lane per STS-1 column interleave. The parities of one frame are checked against the parity bytes carried in the frame that follows it.

The framer upstream supplies each byte twice, as scrambled and as descrambled data, together with its row and column position and an in-frame qualifier. The block keeps sticky error flags, saturating counts of mismatched bits and an interrupt request. A mode input selects the 3-lane layout (155.52 Mbit/s) or the 12-lane layout (622.08 Mbit/s). The interrupt logic and the counter readout are left to the surrounding controller.

Top module: `bip_parity_monitor`

## Requirements
- R1: The section parity of a frame is the XOR of every scrambled byte taken with `byte_valid` high, from the byte at row 0, column 0 up to the last byte before the next row 0, column 0.
- R2: The section parity of one frame is compared with the scrambled byte at row 1, column 0 of the next frame. On a mismatch, `b1_err` goes high and `b1_err_cnt` grows by the number of differing bits, both on the clock edge that takes in that byte.
- R3: Line parity lane i (i = column mod N) is the XOR of the descrambled valid bytes of its columns, leaving out rows 0 to 2 of columns 0 to 3N-1 (the section overhead).
- R4: Lane i of one frame is compared with the descrambled byte at row 4, column i (i < N) of the next frame. On a mismatch, `b2_err` goes high and `b2_err_cnt` grows by the number of differing bits, on the clock edge that takes in that byte.
- R5: With `mode_hi` low, N is 3. With `mode_hi` high, N is 12. This N sets the lane count, the width of the section overhead (3N columns) and the number of row-4 parity bytes that are checked.
- R6: No check is made on a byte taken while `in_frame` is low, and none is made in the first frame that starts after `in_frame` rises. A frame that runs with `in_frame` low leaves the flags and the counts unchanged.
- R7: A cycle with `byte_valid` low is neither accumulated nor checked, whatever its row, column and data are.
- R8: Both counts saturate at 2^CNT_W-1 and do not wrap.
- R9: `irq` is high exactly when `b1_err` or `b2_err` is high.
- R10: `stat_clr` clears both flags and both counts on the next clock. A mismatch in the same cycle still sets its flag, and its count starts again from that cycle's bit count.
- R11: After reset both flags are low, both counts are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_hi | input | 1 | 0: 3-lane layout, 1: 12-lane layout |
| in_frame | input | 1 | Framer reports frame alignment held |
| byte_valid | input | 1 | A byte is present this cycle |
| row | input | ROW_W | Row of the byte, 0 to 8 |
| col | input | COL_W | Column of the byte, 0 to N*COLS_PER_STS-1 |
| scr_byte | input | 8 | Byte as received (scrambled) |
| dsc_byte | input | 8 | Same byte after descrambling |
| stat_clr | input | 1 | Clear flags and counts |
| b1_err | output | 1 | Sticky section parity error |
| b2_err | output | 1 | Sticky line parity error |
| b1_err_cnt | output | CNT_W | Saturating count of mismatched B1 bits |
| b2_err_cnt | output | CNT_W | Saturating count of mismatched B2 bits |
| irq | output | 1 | Interrupt request |

## Verification
Every flag and count reflects the parity byte that caused it on the first clock edge after that byte is presented, and `irq` follows the flags with no added delay. The bench drives inputs on the falling edge. On the next falling edge it compares all outputs with a model that has already applied that byte, so each result is checked in the one cycle where it is due. Idle cycles that carry the B1 or frame-start position with stale data, out-of-frame frames and the unchecked first frame are all covered by the same per-cycle comparison.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef logic [7:0] byte_t;

    // Fixed SONET positions (0-based rows) the checker decodes
    localparam int SOH_ROWS = 3;
    localparam int B1_ROW   = 1;
    localparam int B2_ROW   = 4;

    function automatic logic [3:0] ones8(input byte_t v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'b000, v[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/bpm_bip_lane.sv
module bpm_bip_lane
    import bpm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_start,
    input  logic  take,
    input  byte_t din,
    output byte_t ref_par
);

    typedef struct packed {
        byte_t acc;
        byte_t ref_par;
    } lane_st_t;

    lane_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_start) begin
            s_d.ref_par = s_q.acc;
            s_d.acc     = take ? din : '0;
        end else if (take) begin
            s_d.acc = s_q.acc ^ din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ref_par = s_q.ref_par;

    // R1 / R3: the frozen parity of the last frame moves only at a frame start
    assert_ref_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ref_par));

endmodule

// File: rtl/bpm_err_tally.sv
module bpm_err_tally
    import bpm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             check,
    input  byte_t            seen,
    input  byte_t            want,
    output logic             sticky,
    output logic [CNT_W-1:0] cnt
);

    localparam int             SUM_W   = CNT_W + 1;
    localparam logic [SUM_W-1:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    typedef struct packed {
        logic             sticky;
        logic [CNT_W-1:0] cnt;
    } tally_st_t;

    tally_st_t        s_d, s_q;
    logic [3:0]       nbad;
    logic [SUM_W-1:0] sum;

    always_comb begin
        s_d  = s_q;
        nbad = check ? ones8(seen ^ want) : 4'd0;
        if (clr) begin
            s_d.sticky = 1'b0;
            s_d.cnt    = '0;
        end
        sum = {1'b0, s_d.cnt} + SUM_W'(nbad);
        if (nbad != 4'd0) begin
            s_d.sticky = 1'b1;
            s_d.cnt    = (sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sticky = s_q.sticky;
    assign cnt    = s_q.cnt;

    // R10: only a clear can drop a flag
    assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !clr) |=> sticky);

    // R8: the count never wraps back down
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (int'(cnt) >= int'($past(cnt))));

    // R2 / R4: one parity byte adds at most eight bits
    assert_step_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (int'(cnt) <= int'($past(cnt)) + 8));

    // R2 / R4: a count that grew must come with a raised flag
    assert_flag_with_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> sticky);

endmodule

// File: rtl/bip_parity_monitor.sv
module bip_parity_monitor
    import bpm_pkg::*;
#(
    parameter  int LO_STS       = 3,
    parameter  int HI_STS       = 12,
    parameter  int COLS_PER_STS = 90,
    parameter  int TOH_COLS     = 3,
    parameter  int ROWS         = 9,
    parameter  int CNT_W        = 16,
    localparam int COL_W        = $clog2(HI_STS * COLS_PER_STS),
    localparam int ROW_W        = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_hi,
    input  logic             in_frame,
    input  logic             byte_valid,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [7:0]       scr_byte,
    input  logic [7:0]       dsc_byte,
    input  logic             stat_clr,
    output logic             b1_err,
    output logic             b2_err,
    output logic [CNT_W-1:0] b1_err_cnt,
    output logic [CNT_W-1:0] b2_err_cnt,
    output logic             irq
);

    localparam int               LANE_W = $clog2(HI_STS);
    localparam logic [COL_W-1:0] N_LO   = COL_W'(LO_STS);
    localparam logic [COL_W-1:0] N_HI   = COL_W'(HI_STS);
    localparam logic [COL_W-1:0] SOH_LO = COL_W'(TOH_COLS * LO_STS);
    localparam logic [COL_W-1:0] SOH_HI = COL_W'(TOH_COLS * HI_STS);

    typedef struct packed {
        logic live;    // a frame has been accumulating since alignment
        logic ref_ok;  // frozen parities cover a whole aligned frame
    } ctl_st_t;

    ctl_st_t            c_d, c_q;
    logic               at_start, in_soh, b1_slot, b2_slot;
    logic               b1_check, b2_check;
    logic [COL_W-1:0]   n_sts, soh_cols;
    logic [LANE_W-1:0]  lane;
    logic [HI_STS-1:0]  lane_take;
    byte_t              b1_ref, b2_want;
    byte_t              b2_ref [HI_STS];

    always_comb begin
        n_sts    = mode_hi ? N_HI : N_LO;
        soh_cols = mode_hi ? SOH_HI : SOH_LO;
        lane     = LANE_W'(mode_hi ? (col % N_HI) : (col % N_LO));

        at_start = byte_valid && (row == '0) && (col == '0);
        in_soh   = (row < ROW_W'(SOH_ROWS)) && (col < soh_cols);
        b1_slot  = byte_valid && (row == ROW_W'(B1_ROW)) && (col == '0);
        b2_slot  = byte_valid && (row == ROW_W'(B2_ROW)) && (col < n_sts);
        b1_check = c_q.ref_ok && in_frame && b1_slot;
        b2_check = c_q.ref_ok && in_frame && b2_slot;

        b2_want = '0;
        for (int k = 0; k < HI_STS; k++) begin
            lane_take[k] = byte_valid && !in_soh && (lane == LANE_W'(k));
            if (lane == LANE_W'(k)) begin
                b2_want = b2_ref[k];
            end
        end

        c_d = c_q;
        if (!in_frame) begin
            c_d = '0;
        end else if (at_start) begin
            c_d.ref_ok = c_q.live;
            c_d.live   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // Section parity over the scrambled stream
    bpm_bip_lane u_b1_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (at_start),
        .take        (byte_valid),
        .din         (scr_byte),
        .ref_par     (b1_ref)
    );

    // One line parity lane per STS-1 interleave
    for (genvar g = 0; g < HI_STS; g++) begin : g_b2_lane
        bpm_bip_lane u_b2_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (at_start),
            .take        (lane_take[g]),
            .din         (dsc_byte),
            .ref_par     (b2_ref[g])
        );
    end

    bpm_err_tally #(.CNT_W(CNT_W)) u_b1_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (stat_clr),
        .check  (b1_check),
        .seen   (scr_byte),
        .want   (b1_ref),
        .sticky (b1_err),
        .cnt    (b1_err_cnt)
    );

    bpm_err_tally #(.CNT_W(CNT_W)) u_b2_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (stat_clr),
        .check  (b2_check),
        .seen   (dsc_byte),
        .want   (b2_want),
        .sticky (b2_err),
        .cnt    (b2_err_cnt)
    );

    assign irq = b1_err | b2_err;

    // R6: nothing is counted while alignment is lost
    assert_no_check_oof_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame && !stat_clr) |=> ($stable(b1_err_cnt) && $stable(b2_err_cnt)));

    // R7: an idle cycle leaves both counts alone
    assert_idle_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && !stat_clr) |=> ($stable(b1_err_cnt) && $stable(b2_err_cnt)));

    // R2: the section count moves only after the row 1, column 0 byte
    assert_b1_slot_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(byte_valid && row == ROW_W'(B1_ROW) && col == '0) && !stat_clr)
        |=> $stable(b1_err_cnt));

    // R4 / R5: the line count moves only after a row 4 byte in the first N columns
    assert_b2_slot_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(byte_valid && row == ROW_W'(B2_ROW) && col < (mode_hi ? N_HI : N_LO)) && !stat_clr)
        |=> $stable(b2_err_cnt));

    // R10: a clear with no parity byte present empties both counts
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !byte_valid) |=> (b1_err_cnt == '0 && b2_err_cnt == '0 && !irq));

endmodule

// File: tb/bip_parity_monitor_tb.sv
module bip_parity_monitor_tb;

    localparam int COLS  = 6;
    localparam int CNT_W = 6;
    localparam int MAXC  = (1 << CNT_W) - 1;
    localparam int COL_W = $clog2(12 * COLS);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_hi = 1'b0;
    logic             in_frame = 1'b0;
    logic             byte_valid = 1'b0;
    logic [3:0]       row = '0;
    logic [COL_W-1:0] col = '0;
    logic [7:0]       scr_byte = '0;
    logic [7:0]       dsc_byte = '0;
    logic             stat_clr = 1'b0;
    logic             b1_err, b2_err, irq;
    logic [CNT_W-1:0] b1_err_cnt, b2_err_cnt;

    bip_parity_monitor #(.COLS_PER_STS(COLS), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .in_frame(in_frame),
        .byte_valid(byte_valid), .row(row), .col(col), .scr_byte(scr_byte),
        .dsc_byte(dsc_byte), .stat_clr(stat_clr), .b1_err(b1_err), .b2_err(b2_err),
        .b1_err_cnt(b1_err_cnt), .b2_err_cnt(b2_err_cnt), .irq(irq)
    );

    always #10 clk = ~clk;

    int       n_run = 0, n_fail = 0;
    bit       done = 0;
    int       exp_b1c = 0, exp_b2c = 0;
    bit       exp_b1s = 0, exp_b2s = 0;
    logic [7:0] prev_b1 = '0, cur_b1 = '0, b1m = '0;
    logic [7:0] prev_b2 [12], cur_b2 [12], b2m [12];
    bit       gaps = 0, clr_at_b1 = 0, idle_tog = 0, cur_inf = 0;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2", "b1_err", int'(b1_err), int'(exp_b1s));
        chk("R2", "b1_err_cnt", int'(b1_err_cnt), exp_b1c);
        chk("R4", "b2_err", int'(b2_err), int'(exp_b2s));
        chk("R4", "b2_err_cnt", int'(b2_err_cnt), exp_b2c);
        chk("R9", "irq", int'(irq), int'(exp_b1s | exp_b2s));
    endtask

    function automatic int sat(input int a, input int b);
        return (a + b > MAXC) ? MAXC : a + b;
    endfunction

    task automatic drive(input bit v, input int r, input int c, input logic [7:0] s,
                         input logic [7:0] d, input bit clr);
        @(negedge clk);
        compare_all();
        byte_valid = v;
        row        = 4'(r);
        col        = COL_W'(c);
        scr_byte   = s;
        dsc_byte   = d;
        stat_clr   = clr;
        in_frame   = cur_inf;
    endtask

    // Idle cycle carrying a frame-start or B1 position with stale data (R7)
    task automatic idle();
        idle_tog = ~idle_tog;
        drive(1'b0, idle_tog ? 0 : 1, 0, ~prev_b1, 8'h5A, 1'b0);
    endtask

    task automatic clear_pulse();
        drive(1'b0, 2, 2, 8'h00, 8'h00, 1'b1);
        exp_b1s = 0; exp_b2s = 0; exp_b1c = 0; exp_b2c = 0;
    endtask

    task automatic send_frame(input bit inf, input bit chkd);
        int n;
        n = mode_hi ? 12 : 3;
        cur_inf = inf;
        for (int r = 0; r < 9; r++) begin
            for (int c = 0; c < COLS * n; c++) begin
                logic [7:0] s, d;
                bit clr;
                if (gaps && ((r * 5 + c) % 11 == 3)) idle();
                s = 8'($urandom);
                d = 8'($urandom);
                if (r == 1 && c == 0) s = prev_b1 ^ b1m;
                if (r == 4 && c < n) d = prev_b2[c] ^ b2m[c];
                clr = clr_at_b1 && r == 1 && c == 0;
                drive(1'b1, r, c, s, d, clr);
                if (clr) begin
                    exp_b1s = 0; exp_b2s = 0; exp_b1c = 0; exp_b2c = 0;
                end
                if (chkd && r == 1 && c == 0 && b1m != 0) begin
                    exp_b1s = 1;
                    exp_b1c = sat(exp_b1c, $countones(b1m));
                end
                if (chkd && r == 4 && c < n && b2m[c] != 0) begin
                    exp_b2s = 1;
                    exp_b2c = sat(exp_b2c, $countones(b2m[c]));
                end
                if (r == 0 && c == 0) begin
                    cur_b1 = s;
                    for (int k = 0; k < 12; k++) cur_b2[k] = '0;
                end else begin
                    cur_b1 = cur_b1 ^ s;
                end
                if (!(r < 3 && c < 3 * n)) cur_b2[c % n] = cur_b2[c % n] ^ d;
            end
        end
        prev_b1 = cur_b1;
        for (int k = 0; k < 12; k++) prev_b2[k] = cur_b2[k];
    endtask

    task automatic clear_masks();
        b1m = '0;
        for (int k = 0; k < 12; k++) b2m[k] = '0;
    endtask

    task automatic settle();
        drive(1'b0, 7, 7, 8'h00, 8'h00, 1'b0);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        for (int k = 0; k < 12; k++) begin
            prev_b2[k] = '0; cur_b2[k] = '0; b2m[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "b1_err after reset", int'(b1_err), 0);
        chk("R11", "b2_err after reset", int'(b2_err), 0);
        chk("R11", "counts after reset", int'(b1_err_cnt) + int'(b2_err_cnt), 0);
        chk("R11", "irq after reset", int'(irq), 0);

        // R6: first aligned frame is not checked even with bad parity bytes
        mode_hi = 1'b0;
        b1m = 8'hFF; b2m[0] = 8'hFF;
        send_frame(1, 0);
        settle();
        chk("R6", "first frame b1 count", int'(b1_err_cnt), 0);
        chk("R6", "first frame b2 count", int'(b2_err_cnt), 0);

        // R1, R3: correct parities give no error
        clear_masks();
        send_frame(1, 1);
        settle();
        chk("R1", "clean frame b1 count", int'(b1_err_cnt), 0);
        chk("R3", "clean frame b2 count", int'(b2_err_cnt), 0);

        // R2, R7: two bad B1 bits with idle cycles mixed in
        gaps = 1; b1m = 8'h81;
        send_frame(1, 1);
        settle();
        chk("R2", "b1 count two bits", int'(b1_err_cnt), 2);
        chk("R7", "idle cycles ignored b1 count", int'(b1_err_cnt), 2);
        chk("R9", "irq on b1 error", int'(irq), 1);

        // R4: four bad bits in lane 1
        clear_masks(); b2m[1] = 8'h0F;
        send_frame(1, 1);
        settle();
        chk("R4", "b2 count lane 1", int'(b2_err_cnt), 4);

        // R6: out-of-frame frame, then unchecked first frame
        clear_masks(); b1m = 8'hFF; b2m[2] = 8'hFF;
        send_frame(0, 0);
        send_frame(1, 0);
        clear_masks();
        send_frame(1, 1);
        settle();
        chk("R6", "b1 count unchanged over loss", int'(b1_err_cnt), 2);
        chk("R6", "b2 count unchanged over loss", int'(b2_err_cnt), 4);

        // R10: clear
        clear_pulse();
        settle();
        chk("R10", "clear b1 count", int'(b1_err_cnt), 0);
        chk("R10", "clear b2 flag", int'(b2_err), 0);

        // R5: 12-lane layout
        mode_hi = 1'b1; gaps = 0;
        send_frame(0, 0);
        send_frame(1, 0);
        send_frame(1, 1);
        settle();
        chk("R5", "12-lane clean frame", int'(b2_err_cnt), 0);
        b2m[11] = 8'hFF; b2m[5] = 8'h01;
        send_frame(1, 1);
        settle();
        chk("R5", "12-lane lanes 5 and 11", int'(b2_err_cnt), 9);

        // R10: clear in the same cycle as a B1 mismatch
        clear_masks(); b1m = 8'h07; clr_at_b1 = 1;
        send_frame(1, 1);
        clr_at_b1 = 0;
        settle();
        chk("R10", "error wins over clear flag", int'(b1_err), 1);
        chk("R10", "count restarts from error", int'(b1_err_cnt), 3);
        chk("R10", "b2 cleared", int'(b2_err_cnt), 0);

        // R8: saturation
        b1m = 8'hFF;
        for (int k = 0; k < 12; k++) b2m[k] = 8'hFF;
        send_frame(1, 1);
        settle();
        chk("R8", "b2 count saturates", int'(b2_err_cnt), MAXC);
        for (int f = 0; f < 7; f++) send_frame(1, 1);
        settle();
        chk("R8", "b1 count saturates", int'(b1_err_cnt), MAXC);
        chk("R8", "b2 count held", int'(b2_err_cnt), MAXC);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL R11 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule